// File: doc/BRIEF.md
# Output Driver Impedance Calibration Controller

This block keeps the drive strength of a pad's output stage in step with slow drifts in supply voltage and temperature. A free-running cycle timer raises a one-cycle evaluation strobe at a programmable spacing. On each strobe, the block samples one comparator verdict per leg: make the leg stronger, make it weaker, or leave it. The comparator is a digital stand-in for the analog compare against the external reference resistor. The block holds an independent binary-weighted code for the pull-up leg and for the pull-down leg. Each verdict moves a code by at most one step, and a code never wraps past its end values.

A leg that is driving the pad must not have its code changed. The pull-up leg may take a new code only while the pad outputs 0 or is tri-stated. The pull-down leg may take a new code only while the pad outputs 1 or is tri-stated. A verdict that arrives while its leg is busy is parked in a per-leg shadow register, and it is committed on the first cycle the leg is idle.

Each leg runs a two-state machine. In `SYNCED`, the shadow equals the applied code. In `PENDING`, the shadow holds a step the pad has not yet received. Transition `T_DEFER` (SYNCED to PENDING) is taken when a step is decided while the leg drives. Transition `T_COMMIT` (PENDING to SYNCED) is taken when the leg goes idle, or when a later verdict brings the shadow back to the applied code. All other cycles stay in the current state. The target impedance is one fifth of the reference resistor, and calibration is meaningful for references from 150 to 300 ohms. That range only constrains the analog side.

Top module: `zq_cal_ctrl`

## Requirements
- R1: During and right after reset, both codes equal mid-scale (only the MSB set, 16 for the default 5-bit code), the strobe is low, and the timer starts from zero. The first strobe is seen `interval`+1 clock edges after reset is released.
- R2: `eval_strobe` is high for one cycle every `interval`+1 cycles. With `interval` = 0 it is high on every cycle.
- R3: Each comparator input uses the encoding 2'b01 = one step up (code+1), 2'b10 = one step down (code-1), and 2'b00 or 2'b11 = hold. The input is sampled only on the clock edge that ends a strobe cycle and is ignored on all other edges.
- R4: An evaluation moves a code by exactly one step, or not at all. Between any two consecutive cycles, an applied code changes by at most one.
- R5: Codes saturate: stepping up from all-ones leaves all-ones, and stepping down from zero leaves zero.
- R6: `pd_code` changes only on an edge whose preceding cycle had `out_oe`=0 or `out_data`=1.
- R7: `pu_code` changes only on an edge whose preceding cycle had `out_oe`=0 or `out_data`=0.
- R8: A step decided for a busy leg is held and applied at the end of the first idle cycle, even if that cycle has no strobe. A hold verdict keeps a pending step. A new up or down verdict replaces the pending step with one step from the applied code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval | input | CNT_W | Strobe spacing minus one, in cycles |
| pu_cmd | input | 2 | Pull-up comparator verdict (01 up, 10 down, else hold) |
| pd_cmd | input | 2 | Pull-down comparator verdict (01 up, 10 down, else hold) |
| out_data | input | 1 | Data value currently presented to the pad |
| out_oe | input | 1 | Pad output enable (0 = high impedance) |
| eval_strobe | output | 1 | One-cycle evaluation request |
| pu_code | output | CODE_W | Applied pull-up code |
| pd_code | output | CODE_W | Applied pull-down code |

## Verification
The in-RTL assertions check the following on every cycle:
- a busy leg's applied code is frozen;
- no applied code moves by more than one step;
- the shadow never strays more than a step from the applied code;
- the shadow changes only on a strobe;
- a strobe is followed by a gap whenever the interval is nonzero.

Only the bench's scenarios can show the rest:
- that verdicts land in the right direction;
- that the strobe spacing equals the programmed interval;
- that saturation stops at both ends;
- that a parked step surfaces on the first idle cycle, or is replaced by a later verdict.

// File: rtl/zq_cal_pkg.sv
package zq_cal_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'b00,
        CMD_UP    = 2'b01,
        CMD_DOWN  = 2'b10,
        CMD_HOLDX = 2'b11
    } cmp_cmd_e;

    typedef enum logic {
        SYNCED  = 1'b0,
        PENDING = 1'b1
    } leg_state_e;

    localparam int unsigned NUM_LEGS = 2;
    localparam int unsigned LEG_PU   = 0;
    localparam int unsigned LEG_PD   = 1;

endpackage

// File: rtl/zq_interval_timer.sv
module zq_interval_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] interval,
    output logic             strobe
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             wrap;

    always_comb begin
        wrap  = (cnt_q >= interval);
        cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            strobe <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            strobe <= wrap;
        end
    end

    // R2: with a nonzero interval a strobe is never two cycles long
    p_strobe_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && interval != '0 && $stable(interval)) |=> !strobe);

    // R2: a strobe always follows a counter wrap back to zero
    p_strobe_after_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (cnt_q == '0));

endmodule

// File: rtl/zq_leg_ctrl.sv
module zq_leg_ctrl
    import zq_cal_pkg::*;
#(
    parameter int unsigned CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [1:0]        cmd,
    input  logic              idle,
    output logic [CODE_W-1:0] code
);

    localparam logic [CODE_W-1:0] MID  = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

    leg_state_e        state_q, state_d;
    logic [CODE_W-1:0] shd_q, shd_d;
    logic [CODE_W-1:0] act_q, act_d;
    logic [CODE_W-1:0] step_up, step_dn;

    // saturating neighbours of the applied code
    always_comb begin
        step_up = (act_q == FULL) ? act_q : act_q + 1'b1;
        step_dn = (act_q == '0)   ? act_q : act_q - 1'b1;
    end

    // verdict decode and commit decision
    always_comb begin
        shd_d = shd_q;
        if (strobe) begin
            unique case (cmp_cmd_e'(cmd))
                CMD_UP:    shd_d = step_up;
                CMD_DOWN:  shd_d = step_dn;
                CMD_HOLD,
                CMD_HOLDX: shd_d = shd_q;
                default:   shd_d = shd_q;
            endcase
        end
        act_d = idle ? shd_d : act_q;
    end

    // next-state logic: T_DEFER and T_COMMIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SYNCED:  if (act_d != shd_d) state_d = PENDING;
            PENDING: if (act_d == shd_d) state_d = SYNCED;
            default: state_d = SYNCED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SYNCED;
        else        state_q <= state_d;
    end

    // data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_q <= MID;
            act_q <= MID;
        end else begin
            shd_q <= shd_d;
            act_q <= act_d;
        end
    end

    assign code = act_q;

    // R6 / R7: a leg that drove the pad keeps its code across the edge
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> (act_q == $past(act_q)));

    // R4: applied code moves at most one step per cycle
    p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, act_q} == {1'b0, $past(act_q)}) ||
        ({1'b0, act_q} == {1'b0, $past(act_q)} + 1'b1) ||
        ({1'b0, act_q} + 1'b1 == {1'b0, $past(act_q)}));

    // R5: no wrap between the end values
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(($past(act_q) == FULL && act_q == '0) || ($past(act_q) == '0 && act_q == FULL)));

    // R8: shadow stays within one step of the applied code
    p_shadow_near_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, shd_q} == {1'b0, act_q}) ||
        ({1'b0, shd_q} == {1'b0, act_q} + 1'b1) ||
        ({1'b0, shd_q} + 1'b1 == {1'b0, act_q}));

    // R3: the shadow only changes on a strobe edge
    p_no_eval_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(shd_q));

    // R8: synced state means nothing is parked
    p_state_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SYNCED) |-> (shd_q == act_q));

endmodule

// File: rtl/zq_cal_ctrl.sv
module zq_cal_ctrl
    import zq_cal_pkg::*;
#(
    parameter int unsigned CODE_W = 5,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  interval,
    input  logic [1:0]        pu_cmd,
    input  logic [1:0]        pd_cmd,
    input  logic              out_data,
    input  logic              out_oe,
    output logic              eval_strobe,
    output logic [CODE_W-1:0] pu_code,
    output logic [CODE_W-1:0] pd_code
);

    logic [1:0]        leg_cmd  [NUM_LEGS];
    logic              leg_idle [NUM_LEGS];
    logic [CODE_W-1:0] leg_code [NUM_LEGS];

    zq_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .interval (interval),
        .strobe   (eval_strobe)
    );

    // pull-up is idle when pad shows 0 or is off; pull-down when 1 or off
    always_comb begin
        leg_cmd[LEG_PU]  = pu_cmd;
        leg_cmd[LEG_PD]  = pd_cmd;
        leg_idle[LEG_PU] = !out_oe || !out_data;
        leg_idle[LEG_PD] = !out_oe ||  out_data;
    end

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        zq_leg_ctrl #(.CODE_W(CODE_W)) u_leg (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (eval_strobe),
            .cmd    (leg_cmd[g]),
            .idle   (leg_idle[g]),
            .code   (leg_code[g])
        );
    end

    assign pu_code = leg_code[LEG_PU];
    assign pd_code = leg_code[LEG_PD];

    // R7: pull-up code frozen across an edge while the pad drives 1
    p_pu_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_oe && out_data) |=> $stable(pu_code));

    // R6: pull-down code frozen across an edge while the pad drives 0
    p_pd_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_oe && !out_data) |=> $stable(pd_code));

endmodule

// File: tb/sim_zq_cal_ctrl.sv
module sim_zq_cal_ctrl;

    localparam int unsigned CODE_W = 5;
    localparam int unsigned CNT_W  = 16;
    localparam int unsigned IVAL   = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CNT_W-1:0]  interval = CNT_W'(IVAL);
    logic [1:0]        pu_cmd = 2'b00;
    logic [1:0]        pd_cmd = 2'b00;
    logic              out_data = 1'b0;
    logic              out_oe = 1'b0;
    logic              eval_strobe;
    logic [CODE_W-1:0] pu_code;
    logic [CODE_W-1:0] pd_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    zq_cal_ctrl #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .interval(interval),
        .pu_cmd(pu_cmd), .pd_cmd(pd_cmd),
        .out_data(out_data), .out_oe(out_oe),
        .eval_strobe(eval_strobe), .pu_code(pu_code), .pd_code(pd_code)
    );

    // {data, oe, pu_cmd, pd_cmd, exp_pu, exp_pd}; 01 up, 10 down, 00 hold
    localparam int NV = 6;
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 1'b0, 2'b01, 2'b10, 5'd17, 5'd15},  // both idle, step each
        {1'b1, 1'b1, 2'b01, 2'b10, 5'd17, 5'd14},  // pu busy -> parked
        {1'b0, 1'b1, 2'b00, 2'b00, 5'd18, 5'd14},  // pu idle -> commit
        {1'b0, 1'b1, 2'b00, 2'b01, 5'd18, 5'd14},  // pd busy -> parked up
        {1'b0, 1'b1, 2'b00, 2'b10, 5'd18, 5'd14},  // pd replaced by down
        {1'b0, 1'b0, 2'b00, 2'b00, 5'd18, 5'd13}   // idle -> commit down
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_strobe();
        @(negedge clk);
        while (!eval_strobe) @(negedge clk);
    endtask

    task automatic run_eval(input logic d, input logic oe,
                            input logic [1:0] pc, input logic [1:0] dc);
        wait_strobe();
        out_data = d; out_oe = oe; pu_cmd = pc; pd_cmd = dc;
        @(negedge clk);
    endtask

    initial begin
        int k;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 pu reset", pu_code, 16);
        check("R1 pd reset", pd_code, 16);
        check("R1 strobe reset", eval_strobe, 0);
        rst_n = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (!eval_strobe && k < 50);
        check("R1 first strobe delay", k, IVAL + 1);

        // R2: spacing
        k = 0;
        do begin @(negedge clk); k++; end while (!eval_strobe && k < 50);
        check("R2 strobe period", k, IVAL + 1);

        // table walk: R3 R4 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            run_eval(VEC[i][15], VEC[i][14], VEC[i][13:12], VEC[i][11:10]);
            check($sformatf("R6/R7/R8 vec%0d pu", i), pu_code, int'(VEC[i][9:5]));
            check($sformatf("R6/R7/R8 vec%0d pd", i), pd_code, int'(VEC[i][4:0]));
        end

        // R3: verdicts away from the strobe are ignored
        out_oe = 1'b0; pu_cmd = 2'b10; pd_cmd = 2'b01;
        @(negedge clk);
        check("R3 off-strobe strobe low", eval_strobe, 0);
        check("R3 off-strobe pu", pu_code, 18);
        @(negedge clk);
        check("R3 off-strobe pd", pd_code, 13);
        pu_cmd = 2'b00; pd_cmd = 2'b00;

        // R3: 2'b11 is a hold
        run_eval(1'b0, 1'b0, 2'b11, 2'b11);
        check("R3 code 11 pu hold", pu_code, 18);
        check("R3 code 11 pd hold", pd_code, 13);

        // R8: parked step held over several busy cycles, then applied off-strobe
        run_eval(1'b1, 1'b1, 2'b01, 2'b00);
        pu_cmd = 2'b00;
        check("R7 busy pu parked", pu_code, 18);
        @(negedge clk); @(negedge clk);
        check("R8 still parked", pu_code, 18);
        out_data = 1'b0;
        @(negedge clk);
        check("R8 applied on idle", pu_code, 19);

        // R5: saturation at both ends; R4 single steps
        run_eval(1'b0, 1'b0, 2'b01, 2'b10);
        check("R4 one step pu", pu_code, 20);
        check("R4 one step pd", pd_code, 12);
        for (int i = 0; i < 20; i++) run_eval(1'b0, 1'b0, 2'b01, 2'b10);
        check("R5 pu sat high", pu_code, 31);
        check("R5 pd sat low", pd_code, 0);
        run_eval(1'b0, 1'b0, 2'b10, 2'b01);
        check("R5 pu leaves top", pu_code, 30);
        check("R5 pd leaves bottom", pd_code, 1);

        // R2: interval zero -> strobe every cycle
        pu_cmd = 2'b00; pd_cmd = 2'b00;
        interval = '0;
        @(negedge clk); @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            check("R2 interval zero strobe", eval_strobe, 1);
            @(negedge clk);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R2 watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule